// File: doc/BRIEF.md
# Single-Command SPI Flash Engine

This block is a host-programmed SPI master that runs one serial flash command at a time. Software reaches it through a small byte-addressed register window. It writes an opcode. It sets the number of bytes to send and to receive through an index/data register pair. It rewinds the FIFO pointer and loads the outgoing bytes through an auto-incrementing data port. It then sets an execute bit and polls until the busy flag drops.

One eight-entry byte store serves both directions. Before a command it holds the bytes to send. After the command, the bytes sent occupy the low entries and the bytes captured from the device follow them. Software rewinds the pointer, skips the bytes it sent and reads out the response. The serial side is single-bit, clock mode 0 and MSB first, with the clock rate fixed by a divider parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, the busy bit (bit 7 at 0x03) reads 0, the FIFO pointer reads 0, and both byte counts read 0.
- R2: The byte at offset 0x00 is the opcode. It is always the first byte shifted out and is never stored in the FIFO.
- R3: Each write or read of the data port at offset 0x0c accesses the FIFO entry at the pointer and then increments the pointer, modulo 8.
- R4: Bits 2:0 of the byte at offset 0x0d return the FIFO pointer. Reading that byte does not move the pointer.
- R5: Writing a byte with bit 4 set to offset 0x02 sets the FIFO pointer to 0 on the next clock.
- R6: Offset 0x1e selects an extension entry and offset 0x1f reads or writes it. Entry 5 is the transmit byte count and entry 6 is the receive byte count. Both read back as written.
- R7: Writing a byte with bit 0 set to offset 0x02 starts a command. Bit 0 of 0x02 and bit 7 of 0x03 both read 1 from the next cycle until the command ends, and read 0 afterwards.
- R8: On the bus, chip select falls, then the opcode is sent, then the transmit bytes, then one byte of clocks per receive byte with MOSI at 0x00, and then chip select rises. The bus runs in mode 0 (SCK idle low, sampled on the rising edge), MSB first. The SCK period is 2*SCK_DIV_HALF clocks.
- R9: After a command, FIFO entries 0 to tx-1 hold the bytes that were sent and the entries that follow hold the received bytes, in the order they arrived.
- R10: A transmit count of 0 gives an opcode followed directly by the receive phase. A receive count of 0 ends the command after the transmit bytes.
- R11: The effective transmit count is min(tx, 8). The effective receive count is min(rx, 8 - effective tx). Only those bytes appear on the bus.
- R12: While busy, writes to the opcode, to either byte count and to the data port are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_rd | input | 1 | Register read strobe; advances the pointer when the address is the data port |
| reg_addr | input | 5 | Byte offset in the register window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench runs commands with zero transmit bytes, zero receive bytes, a mix of both, a full eight-byte transmit, and counts that overflow the FIFO. A scoreboard compares every byte seen on MOSI, and the FIFO is read back after each command. These cases catch a design that puts the opcode in the FIFO, which would shift every later byte by one entry. They also catch a design that does not clamp, which would clock extra bytes or overwrite the transmit entries. Pointer reads at 0x0d are repeated to catch a design that advances the pointer on a status read, and the pointer is checked after eight writes to show that it wraps. Writes made while busy are followed by readback of the opcode, count and pointer, which would change if the busy gate were missing.

// File: rtl/spi_eng_pkg.sv
// Shared constants and types for the SPI command engine.
// Register offsets are kept fixed because host software decodes them.
package spi_eng_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_OPCODE    = 5'h00;
    localparam logic [ADDR_W-1:0] A_CTRL_EXEC = 5'h02;
    localparam logic [ADDR_W-1:0] A_STATUS    = 5'h03;
    localparam logic [ADDR_W-1:0] A_FIFO_PORT = 5'h0c;
    localparam logic [ADDR_W-1:0] A_FIFO_PTR  = 5'h0d;
    localparam logic [ADDR_W-1:0] A_EXT_IDX   = 5'h1e;
    localparam logic [ADDR_W-1:0] A_EXT_DAT   = 5'h1f;

    localparam logic [7:0] X_TX_CNT = 8'd5;
    localparam logic [7:0] X_RX_CNT = 8'd6;

    localparam int B_EXEC    = 0;
    localparam int B_PTR_CLR = 4;
    localparam int B_BUSY    = 7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT,
        SQ_TRAIL
    } seq_state_t;
endpackage

// File: rtl/spi_eng_regs.sv
// Host register window: decodes byte accesses into the opcode, the
// extension index and counts, and FIFO port strobes, and muxes read data.
// Assumes at most one access per cycle; a write wins over a read.
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic [7:0]        fifo_rdata,
    input  logic [PTR_W-1:0]  host_ptr,
    output logic [7:0]        opcode,
    output logic [7:0]        tx_cnt,
    output logic [7:0]        rx_cnt,
    output logic              go,
    output logic              ptr_clr,
    output logic              fifo_we,
    output logic              fifo_re,
    output logic [7:0]        fifo_wdata
);
    logic [7:0] ext_idx;

    // Strobes derived from the current host access.
    assign go         = reg_wr && (reg_addr == A_CTRL_EXEC) && reg_wdata[B_EXEC] && !busy;
    assign ptr_clr    = reg_wr && (reg_addr == A_CTRL_EXEC) && reg_wdata[B_PTR_CLR];
    assign fifo_we    = reg_wr && (reg_addr == A_FIFO_PORT) && !busy;
    assign fifo_re    = reg_rd && !reg_wr && (reg_addr == A_FIFO_PORT);
    assign fifo_wdata = reg_wdata;

    // Register writes; command setup is locked while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode  <= '0;
            tx_cnt  <= '0;
            rx_cnt  <= '0;
            ext_idx <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_OPCODE:  if (!busy) opcode <= reg_wdata;
                A_EXT_IDX: ext_idx <= reg_wdata;
                A_EXT_DAT: begin
                    if (!busy) begin
                        if (ext_idx == X_TX_CNT)      tx_cnt <= reg_wdata;
                        else if (ext_idx == X_RX_CNT) rx_cnt <= reg_wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_OPCODE:    reg_rdata = opcode;
            A_CTRL_EXEC: reg_rdata[B_EXEC] = busy;
            A_STATUS:    reg_rdata[B_BUSY] = busy;
            A_FIFO_PORT: reg_rdata = fifo_rdata;
            A_FIFO_PTR:  reg_rdata[PTR_W-1:0] = host_ptr;
            A_EXT_IDX:   reg_rdata = ext_idx;
            A_EXT_DAT: begin
                if (ext_idx == X_TX_CNT)      reg_rdata = tx_cnt;
                else if (ext_idx == X_RX_CNT) reg_rdata = rx_cnt;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_eng_fifo.sv
// Eight-entry (DEPTH) byte store with two ports. The host port uses an
// auto-incrementing pointer; the engine port uses a direct index.
// Assumes DEPTH is a power of two so that the pointer wraps naturally.
// The engine writes only while busy and host writes are gated while busy.
module spi_eng_fifo #(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic             host_re,
    input  logic             ptr_clr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic [PTR_W-1:0] host_ptr,
    input  logic [PTR_W-1:0] eng_idx,
    input  logic             eng_we,
    input  logic [7:0]       eng_wdata,
    output logic [7:0]       eng_rdata
);
    logic [7:0] mem [DEPTH];

    // Entry storage; an engine write takes priority over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (eng_we) begin
            mem[eng_idx] <= eng_wdata;
        end else if (host_we) begin
            mem[host_ptr] <= host_wdata;
        end
    end

    // Host pointer: a clear wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                  host_ptr <= '0;
        else if (ptr_clr)            host_ptr <= '0;
        else if (host_we || host_re) host_ptr <= host_ptr + 1'b1;
    end

    assign host_rdata = mem[host_ptr];
    assign eng_rdata  = mem[eng_idx];
endmodule

// File: rtl/spi_eng_shifter.sv
// Byte shifter for SPI mode 0, MSB first. A start pulse loads a byte.
// SCK toggles every DIV_HALF clocks, MISO is sampled on the rising edge
// and MOSI moves on the falling edge. done pulses after the eighth
// falling edge, with rx_byte holding the captured byte.
// Assumes DIV_HALF >= 1 and that start is not pulsed while active.
module spi_eng_shifter #(
    parameter  int DIV_HALF = 2,
    localparam int DIV_W    = $clog2(DIV_HALF + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic             active;
    logic [7:0]       sh;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;

    // Half-period timing, edge generation and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sh      <= '0;
            bit_q   <= '0;
            div_q   <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                sh     <= tx_byte;
                bit_q  <= '0;
                div_q  <= '0;
                sck    <= 1'b0;
            end else if (active) begin
                if (div_q == DIV_W'(DIV_HALF - 1)) begin
                    div_q <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh    <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign mosi = active ? sh[7] : 1'b0;
endmodule

// File: rtl/spi_eng_seq.sv
// Command sequencer. On go it clamps and latches the byte counts and
// drops chip select. It then feeds the shifter the opcode, the FIFO
// transmit entries and zero bytes for the receive phase, writes each
// received byte back into the FIFO after the transmit entries, and
// raises chip select once the last byte is done.
// Byte n (n >= 1) always maps to FIFO entry n-1.
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       opcode,
    input  logic [7:0]       tx_cnt,
    input  logic [7:0]       rx_cnt,
    input  logic [7:0]       eng_rdata,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic             busy,
    output logic             cs_n,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    output logic [PTR_W-1:0] eng_idx,
    output logic             eng_we,
    output logic [7:0]       eng_wdata
);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    seq_state_t       state;
    logic [LEN_W-1:0] byte_idx;
    logic [LEN_W-1:0] tx_eff;
    logic [LEN_W-1:0] last_idx;
    logic [7:0]       tx_clamp;
    logic [7:0]       room;
    logic [7:0]       rx_clamp;

    // Clamp the requested counts to the FIFO capacity.
    always_comb begin
        tx_clamp = (tx_cnt > DEPTH_B) ? DEPTH_B : tx_cnt;
        room     = DEPTH_B - tx_clamp;
        rx_clamp = (rx_cnt > room) ? room : rx_cnt;
    end

    // Command state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            busy     <= 1'b0;
            cs_n     <= 1'b1;
            byte_idx <= '0;
            tx_eff   <= '0;
            last_idx <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go) begin
                        busy     <= 1'b1;
                        cs_n     <= 1'b0;
                        byte_idx <= '0;
                        tx_eff   <= LEN_W'(tx_clamp);
                        last_idx <= LEN_W'(tx_clamp + rx_clamp);
                        state    <= SQ_LOAD;
                    end
                end
                SQ_LOAD: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (sh_done) begin
                        if (byte_idx == last_idx) begin
                            state <= SQ_TRAIL;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= SQ_LOAD;
                        end
                    end
                end
                SQ_TRAIL: begin
                    cs_n  <= 1'b1;
                    busy  <= 1'b0;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Byte selection for the shifter and receive write-back.
    always_comb begin
        eng_idx = PTR_W'(byte_idx - 1'b1);
        if (byte_idx == '0)         sh_tx = opcode;
        else if (byte_idx <= tx_eff) sh_tx = eng_rdata;
        else                         sh_tx = 8'h00;
    end

    assign sh_start  = (state == SQ_LOAD);
    assign eng_we    = (state == SQ_WAIT) && sh_done && (byte_idx > tx_eff);
    assign eng_wdata = sh_rx;
endmodule

// File: rtl/spi_cmd_engine.sv
// Top level of the single-command SPI flash engine. It connects the
// register window, the shared FIFO, the sequencer and the byte shifter.
// FIFO_DEPTH must be a power of two; the SCK half period is SCK_DIV_HALF
// clocks.
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter  int FIFO_DEPTH   = 8,
    parameter  int SCK_DIV_HALF = 2,
    localparam int PTR_W        = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic             busy;
    logic [7:0]       opcode;
    logic [7:0]       tx_cnt;
    logic [7:0]       rx_cnt;
    logic             go;
    logic             ptr_clr;
    logic             fifo_we;
    logic             fifo_re;
    logic [7:0]       fifo_wdata;
    logic [7:0]       fifo_rdata;
    logic [PTR_W-1:0] host_ptr;
    logic [PTR_W-1:0] eng_idx;
    logic             eng_we;
    logic [7:0]       eng_wdata;
    logic [7:0]       eng_rdata;
    logic             sh_start;
    logic [7:0]       sh_tx;
    logic             sh_done;
    logic [7:0]       sh_rx;

    spi_eng_regs #(.PTR_W(PTR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .fifo_rdata(fifo_rdata), .host_ptr(host_ptr),
        .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .go(go),
        .ptr_clr(ptr_clr), .fifo_we(fifo_we), .fifo_re(fifo_re),
        .fifo_wdata(fifo_wdata)
    );

    spi_eng_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .host_we(fifo_we), .host_re(fifo_re),
        .ptr_clr(ptr_clr), .host_wdata(fifo_wdata), .host_rdata(fifo_rdata),
        .host_ptr(host_ptr), .eng_idx(eng_idx), .eng_we(eng_we),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    spi_eng_seq #(.DEPTH(FIFO_DEPTH)) i_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .eng_rdata(eng_rdata),
        .sh_done(sh_done), .sh_rx(sh_rx), .busy(busy), .cs_n(spi_cs_n),
        .sh_start(sh_start), .sh_tx(sh_tx), .eng_idx(eng_idx),
        .eng_we(eng_we), .eng_wdata(eng_wdata)
    );

    spi_eng_shifter #(.DIV_HALF(SCK_DIV_HALF)) i_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done),
        .rx_byte(sh_rx)
    );
endmodule

// File: rtl/spi_eng_checker.sv
// Protocol and register-window properties for spi_cmd_engine, attached
// to it by the bind statement at the end of this file.
module spi_eng_checker
    import spi_eng_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              busy,
    input logic [PTR_W-1:0]  ptr,
    input logic [7:0]        opcode,
    input logic              spi_cs_n,
    input logic              spi_sck
);
    p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL_EXEC && reg_wdata[B_PTR_CLR]) |=> (ptr == '0));

    p_ptr_peek_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == A_FIFO_PTR) |=> $stable(ptr));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == A_FIFO_PORT) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    p_exec_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL_EXEC && reg_wdata[B_EXEC] && !busy) |=> busy);

    p_busy_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_OPCODE) |=> $stable(opcode));

    p_busy_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_FIFO_PORT && !reg_wdata[B_PTR_CLR]) |=> $stable(ptr));
endmodule

bind spi_cmd_engine spi_eng_checker #(.PTR_W(PTR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
    .ptr(host_ptr), .opcode(opcode), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/test_spi_cmd_engine.sv
// Scoreboard bench: the command driver queues the expected MOSI bytes
// and a bus monitor pops and compares them as they are shifted out.
// A device model returns a known byte pattern on MISO.
module test_spi_cmd_engine;
    import spi_eng_pkg::*;

    localparam int DEPTH = 8;
    localparam int DIVH  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #4 clk = ~clk;

    spi_cmd_engine #(.FIFO_DEPTH(DEPTH), .SCK_DIV_HALF(DIVH)) i_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Device model: byte k of the frame returns resp[k] on MISO.
    logic [7:0] resp [16];
    logic [7:0] txbuf [8];
    int k = 0;
    int b = 0;
    assign spi_miso = resp[k & 15][7 - b];

    always @(negedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            b++;
            if (b == 8) begin
                b = 0;
                k++;
            end
        end
    end

    // Scoreboard monitor.
    logic [7:0] exp_q [$];
    int exp_len = 0;
    int seen = 0;
    int mbits = 0;
    logic [7:0] mshift = '0;
    int cyc = 0;
    int rises = 0;
    int rise0 = 0;

    always @(posedge clk) cyc++;

    always @(negedge spi_cs_n) begin
        seen = 0; mbits = 0; k = 0; b = 0; rises = 0;
    end

    always @(posedge spi_sck) begin
        rises++;
        if (rises == 1) rise0 = cyc;
        if (rises == 2) chk("R8 sck period in clocks", cyc - rise0, 2 * DIVH);
        mshift = {mshift[6:0], spi_mosi};
        mbits++;
        if (mbits == 8) begin
            mbits = 0;
            seen++;
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 unexpected bus byte actual=%0h expected=none", mshift);
            end else begin
                chk("R8 mosi byte", mshift, exp_q.pop_front());
            end
        end
    end

    always @(posedge spi_cs_n) begin
        if (rst_n) begin
            chk("R8 R11 bytes per frame", seen, exp_len);
            chk("R8 scoreboard drained", exp_q.size(), 0);
        end
    end

    // Host access tasks.
    task automatic host_wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(string tag);
        logic [7:0] d;
        int guard;
        guard = 0;
        do begin
            host_rd(A_STATUS, d);
            guard++;
        end while (d[7] && guard < 5000);
        chk({tag, " R7 busy cleared"}, int'(d), 0);
    endtask

    task automatic queue_frame(logic [7:0] op, int txe, int rxe);
        exp_q.push_back(op);
        for (int i = 0; i < txe; i++) exp_q.push_back(txbuf[i]);
        for (int i = 0; i < rxe; i++) exp_q.push_back(8'h00);
        exp_len = 1 + txe + rxe;
    endtask

    task automatic check_fifo(string tag, int txe, int rxe);
        logic [7:0] d;
        host_wr(A_CTRL_EXEC, 8'h10);
        for (int i = 0; i < txe; i++) begin
            host_rd(A_FIFO_PORT, d);
            chk({tag, " R9 sent entry"}, int'(d), int'(txbuf[i]));
        end
        for (int i = 0; i < rxe; i++) begin
            host_rd(A_FIFO_PORT, d);
            chk({tag, " R9 received entry"}, int'(d), int'(resp[1 + txe + i]));
        end
    endtask

    task automatic setup_cmd(logic [7:0] op, int tx, int rx);
        int txe;
        txe = (tx > DEPTH) ? DEPTH : tx;
        host_wr(A_EXT_IDX, X_TX_CNT);
        host_wr(A_EXT_DAT, 8'(tx));
        host_wr(A_EXT_IDX, X_RX_CNT);
        host_wr(A_EXT_DAT, 8'(rx));
        host_wr(A_OPCODE, op);
        host_wr(A_CTRL_EXEC, 8'h10);
        for (int i = 0; i < txe; i++) host_wr(A_FIFO_PORT, txbuf[i]);
        host_wr(A_CTRL_EXEC, 8'h10);
    endtask

    task automatic run_cmd(string tag, logic [7:0] op, int tx, int rx);
        int txe;
        int rxe;
        txe = (tx > DEPTH) ? DEPTH : tx;
        rxe = (rx > DEPTH - txe) ? DEPTH - txe : rx;
        setup_cmd(op, tx, rx);
        queue_frame(op, txe, rxe);
        host_wr(A_CTRL_EXEC, 8'h01);
        wait_idle(tag);
        check_fifo(tag, txe, rxe);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 16; i++) resp[i] = 8'(8'hA1 + i * 8'h17);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 cs_n idle", int'(spi_cs_n), 1);
        chk("R1 sck idle", int'(spi_sck), 0);
        host_rd(A_STATUS, d);   chk("R1 busy", int'(d), 0);
        host_rd(A_FIFO_PTR, d); chk("R1 pointer", int'(d), 0);
        host_wr(A_EXT_IDX, X_TX_CNT);
        host_rd(A_EXT_DAT, d);  chk("R1 tx count", int'(d), 0);

        // R6 count readback
        host_wr(A_EXT_DAT, 8'd3);
        host_wr(A_EXT_IDX, X_RX_CNT);
        host_wr(A_EXT_DAT, 8'd4);
        host_rd(A_EXT_DAT, d);  chk("R6 rx count", int'(d), 4);
        host_wr(A_EXT_IDX, X_TX_CNT);
        host_rd(A_EXT_DAT, d);  chk("R6 tx count", int'(d), 3);

        // R3 R4 R5 pointer behaviour
        host_wr(A_CTRL_EXEC, 8'h10);
        host_wr(A_FIFO_PORT, 8'h11);
        host_rd(A_FIFO_PTR, d); chk("R3 pointer after write", int'(d), 1);
        host_rd(A_FIFO_PTR, d); chk("R4 pointer read is stable", int'(d), 1);
        host_wr(A_CTRL_EXEC, 8'h10);
        host_rd(A_FIFO_PTR, d); chk("R5 pointer cleared", int'(d), 0);
        host_rd(A_FIFO_PORT, d); chk("R3 port read data", int'(d), 8'h11);
        host_rd(A_FIFO_PTR, d); chk("R3 pointer after read", int'(d), 1);

        // R2 R10: no transmit bytes, three received
        run_cmd("R2 R10 tx0", 8'h9F, 0, 3);

        // R2 R9: mixed command
        txbuf[0] = 8'hAA; txbuf[1] = 8'h55; txbuf[2] = 8'hC3;
        run_cmd("R2 R9 mixed", 8'h02, 3, 2);

        // R10: no received bytes
        txbuf[0] = 8'h01; txbuf[1] = 8'h80; txbuf[2] = 8'h7E; txbuf[3] = 8'hFF;
        run_cmd("R10 rx0", 8'h06, 4, 0);

        // R11: counts that overflow the FIFO
        for (int i = 0; i < 8; i++) txbuf[i] = 8'(8'h30 + i * 8'h0B);
        run_cmd("R11 clamp", 8'h0B, 6, 5);
        run_cmd("R11 tx overflow", 8'h4C, 12, 3);

        // R3 pointer wraps after eight port writes
        host_wr(A_CTRL_EXEC, 8'h10);
        for (int i = 0; i < 8; i++) host_wr(A_FIFO_PORT, txbuf[i]);
        host_rd(A_FIFO_PTR, d); chk("R3 pointer wrap", int'(d), 0);
        run_cmd("R9 full tx", 8'h5A, 8, 0);

        // R7 R12: status while busy, writes ignored while busy
        txbuf[0] = 8'hDE; txbuf[1] = 8'hAD;
        setup_cmd(8'h3B, 2, 1);
        queue_frame(8'h3B, 2, 1);
        host_wr(A_CTRL_EXEC, 8'h01);
        host_rd(A_CTRL_EXEC, d); chk("R7 exec bit while busy", int'(d[0]), 1);
        host_rd(A_STATUS, d);    chk("R7 busy bit while busy", int'(d[7]), 1);
        host_wr(A_OPCODE, 8'h77);
        host_wr(A_EXT_IDX, X_TX_CNT);
        host_wr(A_EXT_DAT, 8'd7);
        host_wr(A_FIFO_PORT, 8'hEE);
        host_rd(A_FIFO_PTR, d);  chk("R12 port write ignored", int'(d), 0);
        host_rd(A_OPCODE, d);    chk("R12 opcode write ignored", int'(d), 8'h3B);
        host_rd(A_EXT_DAT, d);   chk("R12 count write ignored", int'(d), 2);
        wait_idle("R12 busy");
        host_rd(A_CTRL_EXEC, d); chk("R7 exec bit cleared", int'(d[0]), 0);
        check_fifo("R12 busy", 2, 1);

        finish_up();
    end
endmodule